// File: doc/BRIEF.md
# Majority Voter with Spare Substitution

This block is the voting core of a redundant datapath. There are N active replicas plus S spare replicas. Each replica delivers one word. A slot map picks N of the N+S words and feeds them into a bitwise majority voter. The voted word is registered and presented together with a one-cycle-delayed valid. In the same cycle, each active word is compared with the majority. Any active replica whose word differs from the majority is marked faulty.

A faulty replica leaves the voting core. Its slot is taken by the lowest-numbered spare that has not been used yet. The new map applies from the next valid sample. The majority already hides a single fault, so the output stays correct during the swap. Once no spares remain, a newly failing replica stays in its slot and a sticky flag reports that the pool is empty. Voting carries on, and the result stays correct while most of the active replicas are healthy.

N must be odd so that the majority is always defined. The replicas themselves are outside this block. Spares sit idle, so their words do not reach the output and are never checked.

Top module: `nmr_spare_voter`

## Requirements
- R1: While rstN is low, voteValid is 0, faultVec is 0 and sparesExhausted is 0. slotMap holds identity: slot i selects replica i, in field slotMap[i*IDXW +: IDXW], where IDXW = clog2(N+S).
- R2: When inValid is high at a clock edge, voteOut after that edge is the bitwise majority of the N words selected by slotMap, and voteValid is 1. Replica k's word lies at modData[k*W +: W].
- R3: When inValid is low at an edge, voteValid becomes 0 and voteOut, slotMap, faultVec and sparesExhausted keep their values.
- R4: When inValid is high and an active replica's word differs from the majority, bit k of faultVec (k being that replica's index) is set. The bit stays set until reset.
- R5: The slot of a replica found faulty is given the lowest unused spare index (N, then N+1, and so on) at the same edge, so the new map is used from the next valid sample. When several slots disagree in one sample, the lower slot gets the lower spare.
- R6: The sample in which a single fault is detected still yields the correct majority on voteOut.
- R7: A fault found when no spare remains leaves slotMap unchanged and sets sparesExhausted, which stays set until reset. Voting continues.
- R8: With three active replicas and one spare, two faults in sequence still give the correct voted output.
- R9: Words of spares that are not in the map, and of replicas that have been removed, affect neither voteOut nor faultVec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modData | input | (N+S)*W | Replica words, replica k at [k*W +: W] |
| inValid | input | 1 | Replica words are valid this cycle |
| voteOut | output | W | Registered majority word |
| voteValid | output | 1 | voteOut updated at the last edge |
| slotMap | output | N*IDXW | Replica index held by each voting slot |
| faultVec | output | N+S | Sticky faulty flag per replica |
| sparesExhausted | output | 1 | A fault occurred with no spare left |

## Verification
The bench builds two copies of the block. The first uses N=3, S=1, W=8. It shows one swap, a removed replica whose later garbage is ignored, and a second fault that finds the pool empty but is still out-voted. The second uses N=5, S=2. Two slots fail in one sample, which exercises the ordering of spares between slots, and a third fault then exhausts the pool.

// File: rtl/nmr_pkg.sv
package nmr_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture the voted word this cycle
  } ctlStrobe_t;
endpackage

// File: rtl/nmr_datapath.sv
module nmr_datapath
  import nmr_pkg::*;
#(
  parameter int N = 3,
  parameter int S = 1,
  parameter int W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [(N+S)*W-1:0]        modData,
  input  logic [N*((N+S)>1 ? $clog2(N+S) : 1)-1:0] slotMap,
  input  ctlStrobe_t                strobe,
  output logic [W-1:0]              voteOut,
  output logic                      voteValid,
  output logic [N-1:0]              disagree
);
  localparam int M    = N + S;
  localparam int IDXW = (M > 1) ? $clog2(M) : 1;
  localparam int HALF = N / 2;

  logic [W-1:0] slotWord [N];
  logic [W-1:0] majority;

  // slot multiplexers
  always_comb begin
    for (int i = 0; i < N; i++) begin
      slotWord[i] = '0;
      for (int k = 0; k < M; k++) begin
        if (slotMap[i*IDXW +: IDXW] == IDXW'(k)) slotWord[i] = modData[k*W +: W];
      end
    end
  end

  // bitwise majority
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [N-1:0] column;
    always_comb begin
      for (int i = 0; i < N; i++) column[i] = slotWord[i][b];
      majority[b] = ($countones(column) > HALF);
    end
  end

  // disagreement vector
  always_comb begin
    for (int i = 0; i < N; i++) disagree[i] = (slotWord[i] != majority);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      voteOut   <= '0;
      voteValid <= 1'b0;
    end else begin
      voteValid <= strobe.load;
      if (strobe.load) voteOut <= majority;
    end
  end

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> voteValid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> (!voteValid && $stable(voteOut))); // R3
endmodule

// File: rtl/nmr_control.sv
module nmr_control
  import nmr_pkg::*;
#(
  parameter int N = 3,
  parameter int S = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [N-1:0]         disagree,
  output logic [N*((N+S)>1 ? $clog2(N+S) : 1)-1:0] slotMap,
  output logic [N+S-1:0]       faultVec,
  output logic                 exhausted,
  output ctlStrobe_t           strobe
);
  localparam int M    = N + S;
  localparam int IDXW = (M > 1) ? $clog2(M) : 1;
  localparam int SCW  = $clog2(S + 1) > 0 ? $clog2(S + 1) : 1;
  localparam logic [SCW-1:0] SMAX = SCW'(S);

  logic [SCW-1:0]    usedCnt, nUsed;
  logic [N*IDXW-1:0] nMap;
  logic [M-1:0]      nFault;
  logic              nExh;

  assign strobe.load = inValid;

  always_comb begin
    nMap   = slotMap;
    nFault = faultVec;
    nUsed  = usedCnt;
    nExh   = exhausted;
    if (inValid) begin
      for (int i = 0; i < N; i++) begin
        if (disagree[i]) begin
          for (int k = 0; k < M; k++) begin
            if (slotMap[i*IDXW +: IDXW] == IDXW'(k)) nFault[k] = 1'b1;
          end
          if (nUsed < SMAX) begin
            nMap[i*IDXW +: IDXW] = IDXW'(N + int'(nUsed));
            nUsed = nUsed + 1'b1;
          end else begin
            nExh = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) slotMap[i*IDXW +: IDXW] <= IDXW'(i);
      faultVec  <= '0;
      usedCnt   <= '0;
      exhausted <= 1'b0;
    end else begin
      slotMap   <= nMap;
      faultVec  <= nFault;
      usedCnt   <= nUsed;
      exhausted <= nExh;
    end
  end

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((faultVec & $past(faultVec)) == $past(faultVec))); // R4
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(slotMap) && $stable(faultVec) && $stable(exhausted))); // R3
  AST_SWAP_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (|disagree) && (usedCnt < SMAX)) |=> (slotMap != $past(slotMap))); // R5
  AST_EXH_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    exhausted |=> exhausted); // R7
  AST_EXH_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(exhausted) |-> $past(inValid && (|disagree))); // R7
endmodule

// File: rtl/nmr_spare_voter.sv
module nmr_spare_voter
  import nmr_pkg::*;
#(
  parameter int N = 3,
  parameter int S = 1,
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [(N+S)*W-1:0]   modData,
  input  logic                 inValid,
  output logic [W-1:0]         voteOut,
  output logic                 voteValid,
  output logic [N*((N+S)>1 ? $clog2(N+S) : 1)-1:0] slotMap,
  output logic [N+S-1:0]       faultVec,
  output logic                 sparesExhausted
);
  ctlStrobe_t   strobe;
  logic [N-1:0] disagree;

  nmr_control #(.N(N), .S(S)) i_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .disagree(disagree),
    .slotMap(slotMap), .faultVec(faultVec), .exhausted(sparesExhausted),
    .strobe(strobe)
  );

  nmr_datapath #(.N(N), .S(S), .W(W)) i_dp (
    .clk(clk), .rstN(rstN), .modData(modData), .slotMap(slotMap),
    .strobe(strobe), .voteOut(voteOut), .voteValid(voteValid),
    .disagree(disagree)
  );
endmodule

// File: tb/test_nmr_spare_voter.sv
`timescale 1ns/1ps
module test_nmr_spare_voter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  // instance A: N=3 S=1 W=8
  logic [31:0] aData = '0;
  logic        aVld  = 1'b0;
  logic [7:0]  aVote;
  logic        aVv, aExh;
  logic [5:0]  aMap;
  logic [3:0]  aFault;

  nmr_spare_voter #(.N(3), .S(1), .W(8)) i_nmr_spare_voter (
    .clk(clk), .rstN(rstN), .modData(aData), .inValid(aVld),
    .voteOut(aVote), .voteValid(aVv), .slotMap(aMap),
    .faultVec(aFault), .sparesExhausted(aExh)
  );

  // instance B: N=5 S=2 W=8
  logic [55:0] bData = '0;
  logic        bVld  = 1'b0;
  logic [7:0]  bVote;
  logic        bVv, bExh;
  logic [14:0] bMap;
  logic [6:0]  bFault;

  nmr_spare_voter #(.N(5), .S(2), .W(8)) i_nmr_spare_voter_b (
    .clk(clk), .rstN(rstN), .modData(bData), .inValid(bVld),
    .voteOut(bVote), .voteValid(bVv), .slotMap(bMap),
    .faultVec(bFault), .sparesExhausted(bExh)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [14:0] pk5(int a, int b, int c, int d, int e);
    return {3'(e), 3'(d), 3'(c), 3'(b), 3'(a)};
  endfunction

  typedef struct packed {
    logic [31:0] mods;
    logic        vld;
    logic [7:0]  vote;
    logic        vv;
    logic [5:0]  map;
    logic [3:0]  fault;
    logic        exh;
  } vec_t;

  // map 6'h24 = identity {2,1,0}; 6'h2C = {2,3,0} (slot1 takes spare 3)
  localparam vec_t TBL [7] = '{
    '{32'h55555555, 1'b1, 8'h55, 1'b1, 6'h24, 4'h0, 1'b0},
    '{32'hFF3C3C3C, 1'b1, 8'h3C, 1'b1, 6'h24, 4'h0, 1'b0},
    '{32'hAAAAAAAA, 1'b0, 8'h3C, 1'b0, 6'h24, 4'h0, 1'b0},
    '{32'h77770077, 1'b1, 8'h77, 1'b1, 6'h2C, 4'h2, 1'b0},
    '{32'h1212EE12, 1'b1, 8'h12, 1'b1, 6'h2C, 4'h2, 1'b0},
    '{32'h44994444, 1'b1, 8'h44, 1'b1, 6'h2C, 4'h6, 1'b1},
    '{32'h81000081, 1'b1, 8'h81, 1'b1, 6'h2C, 4'h6, 1'b1}
  };
  string tags [7] = '{"R2", "R9", "R3", "R4 R5 R6", "R9", "R7", "R8"};

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "A voteValid", 32'(aVv), 32'h0);
    check("R1", "A map", 32'(aMap), 32'h24);
    check("R1", "A fault", 32'(aFault), 32'h0);
    check("R1", "A exh", 32'(aExh), 32'h0);
    check("R1", "B map", 32'(bMap), 32'(pk5(0, 1, 2, 3, 4)));
    rstN = 1'b1;

    for (int r = 0; r < 7; r++) begin
      aData = TBL[r].mods;
      aVld  = TBL[r].vld;
      @(negedge clk);
      check(tags[r], "vote", 32'(aVote), 32'(TBL[r].vote));
      check(tags[r], "voteValid", 32'(aVv), 32'(TBL[r].vv));
      check(tags[r], "map", 32'(aMap), 32'(TBL[r].map));
      check(tags[r], "fault", 32'(aFault), 32'(TBL[r].fault));
      check(tags[r], "exh", 32'(aExh), 32'(TBL[r].exh));
    end
    aVld = 1'b0;

    // B: two slots (1 and 3) disagree in one sample, majority 00
    bData = {8'h00, 8'h00, 8'h00, 8'hF0, 8'h00, 8'h0F, 8'h00};
    bVld  = 1'b1;
    @(negedge clk);
    check("R5", "B vote", 32'(bVote), 32'h00);
    check("R5", "B map two spares", 32'(bMap), 32'(pk5(0, 5, 2, 6, 4)));
    check("R4", "B fault", 32'(bFault), 32'h0A);
    check("R5", "B exh", 32'(bExh), 32'h0);
    // third fault: replica 0, pool empty
    bData = {8'h11, 8'h11, 8'h11, 8'h33, 8'h11, 8'h66, 8'hFF};
    @(negedge clk);
    check("R7", "B vote", 32'(bVote), 32'h11);
    check("R7", "B map kept", 32'(bMap), 32'(pk5(0, 5, 2, 6, 4)));
    check("R7", "B fault", 32'(bFault), 32'h0B);
    check("R7", "B exh", 32'(bExh), 32'h1);
    bVld = 1'b0;

    // reset again restores R1 state
    rstN = 1'b0;
    @(negedge clk);
    check("R1", "A voteValid", 32'(aVv), 32'h0);
    check("R1", "A map", 32'(aMap), 32'h24);
    check("R1", "A fault", 32'(aFault), 32'h0);
    check("R1", "A exh", 32'(aExh), 32'h0);
    check("R1", "B fault", 32'(bFault), 32'h0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule